// File: doc/BRIEF.md
# One-Shot ADC Conversion Sequencer

This block sequences single conversions for a converter with two units. It spans two clocks. The fast bus clock holds the control inputs, the interrupt registers and one result register per unit. The slow converter clock holds the phase sequencer and a small stand-in for the analog converter, which returns a value that can be predicted from the settings.

Software picks a unit and channel through a 4-bit select field and sets an attenuation code. Each unit has its own enable. Software then holds a start level high. The converter domain synchronises that level and triggers on its rising edge. The sequencer then steps through a reset wait, a start wait, a sample window, a capture and a standby wait. The result goes to the register domain through a per-unit toggle. That toggle loads the unit's result register and sets that unit's done bit in the raw interrupt register.

Top module: `adc_oneshot_seq`

## Requirements
- R1: The start level is synchronised into the converter clock, and its rising edge triggers a conversion. A level held for at least 3 converter cycles is always seen. A one-bus-cycle pulse that falls between two converter edges is never seen.
- R2: Bit 3 of the select field picks the unit (0 = unit 1, 1 = unit 2). Bits 2:0 pick the channel. The captured result is {u, a[1:0], c[2:0], ~c[2:0], ~a[1:0], u}, where u is select bit 3, c is the channel and a is the attenuation.
- R3: A trigger starts a conversion only when the enable of the selected unit is set (enable bit 0 = unit 1, bit 1 = unit 2). Otherwise nothing changes.
- R4: The attenuation code present at trigger time is applied to the conversion and appears in the result as given in R2.
- R5: Completion of unit 1 sets interrupt bit 31. Completion of unit 2 sets interrupt bit 30. No other interrupt bit is ever set.
- R6: Raw bits stay set until a one-cycle write-one-to-clear strobe clears them. Strobe bits that are 0 leave raw unchanged. Status equals raw AND enable.
- R7: The phases last 8 (reset), 5 (start), 2 (sample) and 100 (standby) converter cycles. The done bit therefore appears between 17 and 21 converter cycles after the start level rises.
- R8: A start edge that arrives while a conversion or its standby wait is in progress is ignored. The sequencer goes idle only after the result is captured and the standby wait has ended.
- R9: Each conversion sets its raw bit exactly once. After the bit is cleared, it stays clear until another conversion completes.
- R10: A unit's result register keeps its value until that same unit completes another conversion.
- R11: After reset, the raw, status and both result registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register-side clock |
| bus_rst_n | input | 1 | Register-side asynchronous reset, active low |
| adc_clk | input | 1 | Slow converter-side clock |
| adc_rst_n | input | 1 | Converter-side asynchronous reset, active low |
| go_i | input | 1 | Start level, bus domain |
| chan_sel_i | input | 4 | Bit 3 unit, bits 2:0 channel |
| atten_i | input | 2 | Attenuation code |
| unit_en_i | input | 2 | Per-unit one-shot enable |
| int_ena_i | input | 32 | Interrupt enable mask |
| int_clr_i | input | 32 | Write-one-to-clear strobe, one bus cycle |
| int_raw_o | output | 32 | Latched interrupt events |
| int_st_o | output | 32 | Raw AND enable |
| unit1_data_o | output | RES_W | Last result of unit 1 |
| unit2_data_o | output | RES_W | Last result of unit 2 |

## Verification
The hardest case to reach from the ports is a second start edge that arrives while the sequencer is busy. Only the absence of an event shows that the edge was ignored. The stimulus raises a clean start during the 100-cycle standby, after the first done bit has been cleared. It then waits past the point where a second conversion would have finished and checks that raw stays clear and that both results are unchanged. The missed short pulse is created by placing a one-bus-cycle start just after a converter edge, so that no converter edge can sample it.

// File: rtl/adc_os_pkg.sv
package adc_os_pkg;
   localparam int IRQ_W       = 32;
   localparam int U1_IRQ_BIT  = 31;
   localparam int U2_IRQ_BIT  = 30;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RSTW,
      ST_STRT,
      ST_SAMP,
      ST_CONV,
      ST_STBY
   } seq_state_e;
endpackage

// File: rtl/adc_os_start_sync.sv
module adc_os_start_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("adc_os_start_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         last  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], lvl_i};
         last  <= chain[STAGES-1];
      end
   end

   assign rise_o = chain[STAGES-1] & ~last;

   assert_single_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/adc_os_stub.sv
module adc_os_stub #(
   parameter int RES_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             unit_i,
   input  logic [2:0]       chan_i,
   input  logic [1:0]       atten_i,
   output logic             valid_o,
   output logic [RES_W-1:0] data_o
);
   logic [11:0]      base;
   logic [RES_W-1:0] shaped;

   assign base = {unit_i, atten_i, chan_i, ~chan_i, ~atten_i, unit_i};

   if (RES_W >= 12) begin : g_wide
      assign shaped = RES_W'(base);
   end else begin : g_narrow
      assign shaped = base[RES_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         data_o  <= '0;
      end else begin
         valid_o <= req_i;
         if (req_i) data_o <= shaped;
      end
   end
endmodule

// File: rtl/adc_os_seq.sv
module adc_os_seq
   import adc_os_pkg::*;
#(
   parameter int RES_W        = 12,
   parameter int RST_WAIT     = 8,
   parameter int START_WAIT   = 5,
   parameter int SAMPLE_CYC   = 2,
   parameter int STANDBY_WAIT = 100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_i,
   input  logic [3:0]       sel_i,
   input  logic [1:0]       atten_i,
   input  logic [1:0]       unit_en_i,
   input  logic             res_valid_i,
   input  logic [RES_W-1:0] res_data_i,
   output logic             req_o,
   output logic             cur_unit_o,
   output logic [2:0]       cur_chan_o,
   output logic [1:0]       cur_atten_o,
   output logic [RES_W-1:0] hold_o,
   output logic [1:0]       tog_o
);
   localparam int MAXW  = (STANDBY_WAIT > RST_WAIT) ? STANDBY_WAIT : RST_WAIT;
   localparam int CNT_W = $clog2(MAXW + 1);
   localparam int DW_W  = CNT_W + 2;

   if (RST_WAIT < 1 || START_WAIT < 1 || SAMPLE_CYC < 1 || STANDBY_WAIT < 1) begin : g_bad_wait
      $error("adc_os_seq: every phase length must be at least 1");
   end
   if (START_WAIT > MAXW || SAMPLE_CYC > MAXW) begin : g_bad_order
      $error("adc_os_seq: start and sample waits must not exceed the longest wait");
   end

   seq_state_e       st;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         cnt         <= '0;
         cur_unit_o  <= 1'b0;
         cur_chan_o  <= '0;
         cur_atten_o <= '0;
         hold_o      <= '0;
         tog_o       <= '0;
      end else begin
         case (st)
            ST_IDLE: if (trig_i && unit_en_i[sel_i[3]]) begin
               st          <= ST_RSTW;
               cnt         <= CNT_W'(RST_WAIT - 1);
               cur_unit_o  <= sel_i[3];
               cur_chan_o  <= sel_i[2:0];
               cur_atten_o <= atten_i;
            end
            ST_RSTW: if (cnt == '0) begin
               st  <= ST_STRT;
               cnt <= CNT_W'(START_WAIT - 1);
            end else cnt <= cnt - 1'b1;
            ST_STRT: if (cnt == '0) begin
               st  <= ST_SAMP;
               cnt <= CNT_W'(SAMPLE_CYC - 1);
            end else cnt <= cnt - 1'b1;
            ST_SAMP: if (cnt == '0) st <= ST_CONV;
                     else cnt <= cnt - 1'b1;
            ST_CONV: if (res_valid_i) begin
               hold_o             <= res_data_i;
               tog_o[cur_unit_o]  <= ~tog_o[cur_unit_o];
               st                 <= ST_STBY;
               cnt                <= CNT_W'(STANDBY_WAIT - 1);
            end
            ST_STBY: if (cnt == '0) st <= ST_IDLE;
                     else cnt <= cnt - 1'b1;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_o = (st == ST_SAMP) && (cnt == '0);

   // dwell checker: cycles spent in the state just left
   seq_state_e      st_d1;
   logic [DW_W-1:0] dwell;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_d1 <= ST_IDLE;
         dwell <= '0;
      end else begin
         st_d1 <= st;
         dwell <= (st == st_d1) ? dwell + 1'b1 : DW_W'(1);
      end
   end

   assert_rst_phase_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st != st_d1 && st_d1 == ST_RSTW) |-> dwell == DW_W'(RST_WAIT));
   assert_start_phase_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st != st_d1 && st_d1 == ST_STRT) |-> dwell == DW_W'(START_WAIT));
   assert_sample_phase_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st != st_d1 && st_d1 == ST_SAMP) |-> dwell == DW_W'(SAMPLE_CYC));
   assert_standby_phase_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st != st_d1 && st_d1 == ST_STBY) |-> dwell == DW_W'(STANDBY_WAIT));
   assert_enabled_unit_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && trig_i && unit_en_i[sel_i[3]]) |=> st == ST_RSTW);
   assert_disabled_unit_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && trig_i && !unit_en_i[sel_i[3]]) |=> st == ST_IDLE);
   assert_no_restart_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE && st != ST_RSTW) |=> st != ST_RSTW);
   assert_idle_after_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && st_d1 != ST_IDLE) |-> st_d1 == ST_STBY);
endmodule

// File: rtl/adc_os_irq.sv
module adc_os_irq
   import adc_os_pkg::*;
#(
   parameter int RES_W  = 12,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       tog_i,
   input  logic [RES_W-1:0] hold_i,
   input  logic [IRQ_W-1:0] ena_i,
   input  logic [IRQ_W-1:0] clr_i,
   output logic [IRQ_W-1:0] raw_o,
   output logic [IRQ_W-1:0] st_o,
   output logic [RES_W-1:0] u1_data_o,
   output logic [RES_W-1:0] u2_data_o
);
   localparam int IRQ_POS [2] = '{U1_IRQ_BIT, U2_IRQ_BIT};

   logic [1:0]       done_p;
   logic [IRQ_W-1:0] set_v;

   for (genvar u = 0; u < 2; u++) begin : g_unit
      logic [STAGES-1:0] chain;
      logic              last;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
         end else begin
            chain <= {chain[STAGES-2:0], tog_i[u]};
            last  <= chain[STAGES-1];
         end
      end
      assign done_p[u] = chain[STAGES-1] ^ last;

      assert_one_event_per_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
         done_p[u] |=> !done_p[u]);
   end

   always_comb begin
      set_v = '0;
      for (int u = 0; u < 2; u++) set_v[IRQ_POS[u]] = done_p[u];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_o     <= '0;
         u1_data_o <= '0;
         u2_data_o <= '0;
      end else begin
         raw_o <= (raw_o & ~clr_i) | set_v;
         if (done_p[0]) u1_data_o <= hold_i;
         if (done_p[1]) u2_data_o <= hold_i;
      end
   end

   assign st_o = raw_o & ena_i;

   assert_u1_irq_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_p[0] |=> raw_o[U1_IRQ_BIT]);
   assert_u2_irq_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_p[1] |=> raw_o[U2_IRQ_BIT]);
   assert_u1_data_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !done_p[0] |=> $stable(u1_data_o));
   assert_u2_data_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !done_p[1] |=> $stable(u2_data_o));
endmodule

// File: rtl/adc_oneshot_seq.sv
module adc_oneshot_seq
   import adc_os_pkg::*;
#(
   parameter int RES_W        = 12,
   parameter int SYNC_STAGES  = 2,
   parameter int RST_WAIT     = 8,
   parameter int START_WAIT   = 5,
   parameter int SAMPLE_CYC   = 2,
   parameter int STANDBY_WAIT = 100
) (
   input  logic             bus_clk,
   input  logic             bus_rst_n,
   input  logic             adc_clk,
   input  logic             adc_rst_n,
   input  logic             go_i,
   input  logic [3:0]       chan_sel_i,
   input  logic [1:0]       atten_i,
   input  logic [1:0]       unit_en_i,
   input  logic [31:0]      int_ena_i,
   input  logic [31:0]      int_clr_i,
   output logic [31:0]      int_raw_o,
   output logic [31:0]      int_st_o,
   output logic [RES_W-1:0] unit1_data_o,
   output logic [RES_W-1:0] unit2_data_o
);
   if (RES_W < 4) begin : g_bad_res
      $error("adc_oneshot_seq: RES_W must be at least 4");
   end

   logic             trig;
   logic             req;
   logic             cur_unit;
   logic [2:0]       cur_chan;
   logic [1:0]       cur_atten;
   logic             res_valid;
   logic [RES_W-1:0] res_data;
   logic [RES_W-1:0] hold;
   logic [1:0]       tog;

   adc_os_start_sync #(.STAGES(SYNC_STAGES)) u_start (
      .clk    (adc_clk),
      .rst_n  (adc_rst_n),
      .lvl_i  (go_i),
      .rise_o (trig)
   );

   adc_os_seq #(
      .RES_W        (RES_W),
      .RST_WAIT     (RST_WAIT),
      .START_WAIT   (START_WAIT),
      .SAMPLE_CYC   (SAMPLE_CYC),
      .STANDBY_WAIT (STANDBY_WAIT)
   ) u_seq (
      .clk         (adc_clk),
      .rst_n       (adc_rst_n),
      .trig_i      (trig),
      .sel_i       (chan_sel_i),
      .atten_i     (atten_i),
      .unit_en_i   (unit_en_i),
      .res_valid_i (res_valid),
      .res_data_i  (res_data),
      .req_o       (req),
      .cur_unit_o  (cur_unit),
      .cur_chan_o  (cur_chan),
      .cur_atten_o (cur_atten),
      .hold_o      (hold),
      .tog_o       (tog)
   );

   adc_os_stub #(.RES_W(RES_W)) u_stub (
      .clk     (adc_clk),
      .rst_n   (adc_rst_n),
      .req_i   (req),
      .unit_i  (cur_unit),
      .chan_i  (cur_chan),
      .atten_i (cur_atten),
      .valid_o (res_valid),
      .data_o  (res_data)
   );

   adc_os_irq #(.RES_W(RES_W), .STAGES(SYNC_STAGES)) u_irq (
      .clk       (bus_clk),
      .rst_n     (bus_rst_n),
      .tog_i     (tog),
      .hold_i    (hold),
      .ena_i     (int_ena_i),
      .clr_i     (int_clr_i),
      .raw_o     (int_raw_o),
      .st_o      (int_st_o),
      .u1_data_o (unit1_data_o),
      .u2_data_o (unit2_data_o)
   );
endmodule

// File: tb/adc_oneshot_seq_tb.sv
module adc_oneshot_seq_tb;
   logic        bus_clk = 1'b0, adc_clk = 1'b0;
   logic        bus_rst_n = 1'b0, adc_rst_n = 1'b0;
   logic        go = 1'b0;
   logic [3:0]  sel = '0;
   logic [1:0]  att = '0;
   logic [1:0]  en = '0;
   logic [31:0] ena = '0, clr = '0;
   logic [31:0] raw, sts;
   logic [11:0] d1, d2;

   int total = 0, bad = 0;
   int slow_edges = 0;
   logic [11:0] m1 = '0, m2 = '0;

   always #10  bus_clk = ~bus_clk;
   always #100 adc_clk = ~adc_clk;
   always @(posedge adc_clk) slow_edges++;

   adc_oneshot_seq u_dut (
      .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .adc_clk(adc_clk), .adc_rst_n(adc_rst_n),
      .go_i(go), .chan_sel_i(sel), .atten_i(att), .unit_en_i(en),
      .int_ena_i(ena), .int_clr_i(clr), .int_raw_o(raw), .int_st_o(sts),
      .unit1_data_o(d1), .unit2_data_o(d2)
   );

   // [8] unit, [7:5] channel, [4:3] atten, [2:1] enables, [0] expected to run
   localparam logic [8:0] VEC [8] = '{
      {1'b0, 3'd5, 2'd2, 2'b01, 1'b1},
      {1'b1, 3'd3, 2'd1, 2'b10, 1'b1},
      {1'b0, 3'd0, 2'd0, 2'b11, 1'b1},
      {1'b1, 3'd7, 2'd3, 2'b11, 1'b1},
      {1'b0, 3'd2, 2'd1, 2'b10, 1'b0},
      {1'b1, 3'd4, 2'd2, 2'b01, 1'b0},
      {1'b1, 3'd1, 2'd0, 2'b10, 1'b1},
      {1'b0, 3'd6, 2'd3, 2'b01, 1'b1}
   };

   function automatic logic [11:0] exp_res(logic u, logic [2:0] c, logic [1:0] a);
      return {u, a, c, ~c, ~a, u};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic slow(input int n);
      repeat (n) @(posedge adc_clk);
      @(negedge bus_clk);
   endtask

   task automatic start_pulse();
      @(posedge adc_clk); #5 go = 1'b1;
      repeat (4) @(posedge adc_clk);
      #5 go = 1'b0;
   endtask

   task automatic clear(input logic [31:0] m);
      @(negedge bus_clk) clr = m;
      @(negedge bus_clk) clr = '0;
      @(negedge bus_clk);
   endtask

   // waits for done bit; returns converter edges from start rise
   task automatic run_and_wait(input logic [31:0] bitm, output int lat, output bit seen);
      int base;
      seen = 1'b0;
      @(posedge adc_clk); #5 go = 1'b1; base = slow_edges;
      fork
         begin repeat (4) @(posedge adc_clk); #5 go = 1'b0; end
         begin
            for (int i = 0; i < 4000 && !seen; i++) begin
               @(negedge bus_clk);
               if ((raw & bitm) != 0) seen = 1'b1;
            end
         end
      join
      lat = slow_edges - base;
   endtask

   initial begin
      repeat (150000) @(posedge bus_clk);
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int lat;
      bit seen;
      logic [31:0] bm, er;
      repeat (3) @(posedge adc_clk);
      bus_rst_n = 1'b1; adc_rst_n = 1'b1;
      @(negedge bus_clk);
      // R11 reset state
      chk(raw == 0, "R11 raw", raw, 0);
      chk(sts == 0, "R11 status", sts, 0);
      chk(d1 == 0 && d2 == 0, "R11 data", {d1, 8'h0, d2}, 0);

      ena = 32'h4000_0000;
      for (int v = 0; v < 8; v++) begin
         logic u; logic [2:0] c; logic [1:0] a;
         {u, c, a, en} = {VEC[v][8:1]};
         sel = {u, c}; att = a;
         bm = u ? 32'h4000_0000 : 32'h8000_0000;
         if (VEC[v][0]) begin
            run_and_wait(bm, lat, seen);
            chk(seen, "R3 enabled unit converts", 32'(seen), 1);
            chk(lat >= 17 && lat <= 21, "R7 latency", lat, 19);
            @(negedge bus_clk);
            if (u) m2 = exp_res(u, c, a); else m1 = exp_res(u, c, a);
            er = seen ? bm : 0;
         end else begin
            start_pulse();
            slow(40);
            er = 0;
         end
         chk(raw == er, "R5 raw bit position", raw, er);
         chk(sts == (er & ena), "R6 status", sts, er & ena);
         chk(d1 == m1, "R2 R4 R10 unit1 data", d1, m1);
         chk(d2 == m2, "R2 R4 R10 unit2 data", d2, m2);
         clear(32'h0000_0001);
         chk(raw == er, "R6 zero mask keeps raw", raw, er);
         clear(32'hC000_0000);
         chk(raw == 0, "R6 w1c clears", raw, 0);
         slow(110);
         chk(raw == 0, "R9 no repeat event", raw, 0);
      end

      // R1: one-bus-cycle pulse between converter edges
      sel = 4'h2; att = 2'd1; en = 2'b11;
      @(posedge adc_clk); #5 go = 1'b1; #20 go = 1'b0;
      slow(40);
      chk(raw == 0, "R1 short pulse missed", raw, 0);
      chk(d1 == m1, "R1 data unchanged", d1, m1);

      // R8: start during standby ignored
      sel = 4'h9; att = 2'd2; en = 2'b10;
      run_and_wait(32'h4000_0000, lat, seen);
      chk(seen, "R1 held level triggers", 32'(seen), 1);
      m2 = exp_res(1'b1, 3'd1, 2'd2);
      clear(32'hC000_0000);
      sel = 4'hE; att = 2'd3;
      start_pulse();
      slow(130);
      chk(raw == 0, "R8 busy start ignored", raw, 0);
      chk(d2 == m2, "R8 data unchanged", d2, m2);
      // fresh start after idle is accepted
      run_and_wait(32'h4000_0000, lat, seen);
      @(negedge bus_clk);
      m2 = exp_res(1'b1, 3'd6, 2'd3);
      chk(raw == 32'h4000_0000, "R8 accepted after idle", raw, 32'h4000_0000);
      chk(d2 == m2, "R4 new atten applied", d2, m2);
      ena = 32'hFFFF_FFFF;
      @(negedge bus_clk);
      chk(sts == raw, "R6 status full enable", sts, raw);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule